// File: doc/BRIEF.md
# Byte-Controlled Bidirectional Latched Transceiver

This block moves 16-bit data between two buses, called side A and side B, and holds a copy of the data in each direction. Each direction has its own bank of data latches. One bank samples the A bus and feeds side B. The other bank samples the B bus and feeds side A. The data word is split into two bytes, and each byte has its own controls. Each byte in each direction has three active-low controls: a chip select, a capture control and a drive control. Data passes through without inversion. To get full 16-bit operation, the integrator ties the two bytes' controls together.

Latch behaviour is modelled synchronously. On each rising clock edge a byte captures its source bus if its chip select and capture control are both low. Otherwise it keeps its contents. Three-state pads are not modelled directly. Instead, each direction presents a data value and one drive-enable per byte. The data bits of a byte that is not driving read zero. A per-byte conflict flag goes high when both directions would drive the same byte at once. The reset input is asynchronous and active low. Inside the block it is released in step with the clock, and it clears both latch banks.

Top module: `bidir_byte_latch_xcvr`

## Requirements
- R1: While reset is asserted, and after it is released, every byte of both latch banks holds zero until its first capture. Enabling a byte's outputs at that point shows 0x00.
- R2: On a rising clock edge where an A-to-B byte has `ab_sel_n` low and `ab_cap_n` low, that byte stores the value on `a_in`. The stored value is seen on `b_val` from just after that edge.
- R3: A byte keeps its stored value across an edge where its chip select is high or its capture control is high. After the capture control rises, the byte holds the value sampled at the last edge where both were low.
- R4: `b_drv[n]` is 1 exactly when `ab_sel_n[n]` and `ab_out_n[n]` are both 0. This follows the inputs in the same cycle.
- R5: While `b_drv[n]` is 1, byte n of `b_val` equals that byte's stored A-to-B value, not inverted. While `b_drv[n]` is 0, that byte of `b_val` is 0x00. Turning the drive off does not disturb the stored value.
- R6: Byte 0 uses bits 7:0 and control index 0. Byte 1 uses bits 15:8 and control index 1. The control of one byte never affects the other byte.
- R7: The B-to-A path behaves the same way. Its source is `b_in`, its controls are `ba_sel_n`, `ba_cap_n` and `ba_out_n`, and its outputs are `a_val` and `a_drv`.
- R8: `clash[n]` is 1 exactly when `a_drv[n]` and `b_drv[n]` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 16 | Value seen on the A bus |
| b_in | input | 16 | Value seen on the B bus |
| ab_sel_n | input | 2 | A-to-B chip select per byte, active low |
| ab_cap_n | input | 2 | A-to-B capture control per byte, active low |
| ab_out_n | input | 2 | A-to-B drive control per byte, active low |
| ba_sel_n | input | 2 | B-to-A chip select per byte, active low |
| ba_cap_n | input | 2 | B-to-A capture control per byte, active low |
| ba_out_n | input | 2 | B-to-A drive control per byte, active low |
| b_val | output | 16 | Value presented to the B pads |
| b_drv | output | 2 | Per-byte drive enable for the B pads |
| a_val | output | 16 | Value presented to the A pads |
| a_drv | output | 2 | Per-byte drive enable for the A pads |
| clash | output | 2 | Per-byte flag: both directions driving |

## Verification
The bench first raises the capture control with new data already on the bus. A design that still samples on that edge would overwrite the held byte. It then toggles the drive control while the latch holds, to catch a design that clears or reloads the latch when its outputs turn off. It also raises the chip select with the capture control low, which catches a design that decodes transparency from the capture control alone. Finally, it runs every combination of the twelve control inputs with changing data against a model of the control table. This exposes swapped byte lanes, inverted data, a drive that ignores the chip select, and a conflict flag that misses or invents overlaps.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // One byte's control set for a single direction; all fields active low.
  typedef struct packed {
    logic sel_n;
    logic cap_n;
    logic out_n;
  } byte_ctl_t;

endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_r;
  logic [STAGES-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain_r[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else        chain_r <= chain_nxt;
  end

  assign rst_n_sync = chain_r[STAGES-1];

endmodule

// File: rtl/xcvr_byte_latch.sv
module xcvr_byte_latch #(
  parameter int BW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  xcvr_pkg::byte_ctl_t  ctl,
  input  logic [BW-1:0]        din,
  output logic [BW-1:0]        dout,
  output logic                 drv
);

  logic [BW-1:0] hold_r;
  logic [BW-1:0] hold_nxt;
  logic          cap_en;
  logic          seen_r;

  // Next-state: capture while selected and transparent.
  always_comb begin
    cap_en   = ~ctl.sel_n & ~ctl.cap_n;
    hold_nxt = hold_r;
    if (cap_en) hold_nxt = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_r <= '0;
    else if (cap_en) hold_r <= hold_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_r <= 1'b0;
    else        seen_r <= 1'b1;
  end

  // Output stage: drive only when selected and output enabled.
  always_comb begin
    drv  = ~ctl.sel_n & ~ctl.out_n;
    dout = drv ? hold_r : '0;
  end

  // R1: contents are zero at the first edge after reset release
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_r |-> hold_r == '0);

  // R2: a transparent edge loads the input value
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.sel_n && !ctl.cap_n) |=> hold_r == $past(din));

  // R3: a deselected or closed latch keeps its value
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sel_n || ctl.cap_n) |=> $stable(hold_r));

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path #(
  parameter int NB = 2,
  parameter int BW = 8,
  localparam int DW = NB * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic [NB-1:0] sel_n,
  input  logic [NB-1:0] cap_n,
  input  logic [NB-1:0] out_n,
  output logic [DW-1:0] val,
  output logic [NB-1:0] drv
);

  for (genvar g = 0; g < NB; g++) begin : g_byte
    xcvr_pkg::byte_ctl_t ctl;

    always_comb begin
      ctl.sel_n = sel_n[g];
      ctl.cap_n = cap_n[g];
      ctl.out_n = out_n[g];
    end

    xcvr_byte_latch #(.BW(BW)) u_lat (
      .clk  (clk),
      .rst_n(rst_n),
      .ctl  (ctl),
      .din  (src[g*BW +: BW]),
      .dout (val[g*BW +: BW]),
      .drv  (drv[g])
    );

    // R5: an undriven byte lane presents zero
    p_undriven_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !drv[g] |-> val[g*BW +: BW] == '0);
  end

endmodule

// File: rtl/bidir_byte_latch_xcvr.sv
module bidir_byte_latch_xcvr #(
  parameter int NUM_BYTES = 2,
  parameter int BYTE_W    = 8,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic [NUM_BYTES-1:0] ab_sel_n,
  input  logic [NUM_BYTES-1:0] ab_cap_n,
  input  logic [NUM_BYTES-1:0] ab_out_n,
  input  logic [NUM_BYTES-1:0] ba_sel_n,
  input  logic [NUM_BYTES-1:0] ba_cap_n,
  input  logic [NUM_BYTES-1:0] ba_out_n,
  output logic [DATA_W-1:0] b_val,
  output logic [NUM_BYTES-1:0] b_drv,
  output logic [DATA_W-1:0] a_val,
  output logic [NUM_BYTES-1:0] a_drv,
  output logic [NUM_BYTES-1:0] clash
);

  logic rst_n_sync;

  xcvr_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  // A-side source feeding the B pads (R2..R5)
  xcvr_path #(.NB(NUM_BYTES), .BW(BYTE_W)) u_ab (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .src  (a_in),
    .sel_n(ab_sel_n),
    .cap_n(ab_cap_n),
    .out_n(ab_out_n),
    .val  (b_val),
    .drv  (b_drv)
  );

  // B-side source feeding the A pads (R7)
  xcvr_path #(.NB(NUM_BYTES), .BW(BYTE_W)) u_ba (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .src  (b_in),
    .sel_n(ba_sel_n),
    .cap_n(ba_cap_n),
    .out_n(ba_out_n),
    .val  (a_val),
    .drv  (a_drv)
  );

  // R8: both directions enabled onto the same byte lane
  always_comb begin
    clash = a_drv & b_drv;
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_chk
    p_clash_src_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
      clash[g] |-> (!ab_sel_n[g] && !ab_out_n[g] && !ba_sel_n[g] && !ba_out_n[g]));

    p_drive_src_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
      b_drv[g] |-> (!ab_sel_n[g] && !ab_out_n[g]));
  end

endmodule

// File: tb/bidir_byte_latch_xcvr_tb.sv
module bidir_byte_latch_xcvr_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] a_in, b_in;
  logic [1:0]  ab_sel_n, ab_cap_n, ab_out_n;
  logic [1:0]  ba_sel_n, ba_cap_n, ba_out_n;
  logic [15:0] b_val, a_val;
  logic [1:0]  b_drv, a_drv, clash;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // reference model of stored bytes
  logic [7:0] ref_ab [2];
  logic [7:0] ref_ba [2];

  bidir_byte_latch_xcvr u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_sel_n(ab_sel_n), .ab_cap_n(ab_cap_n), .ab_out_n(ab_out_n),
    .ba_sel_n(ba_sel_n), .ba_cap_n(ba_cap_n), .ba_out_n(ba_out_n),
    .b_val(b_val), .b_drv(b_drv), .a_val(a_val), .a_drv(a_drv), .clash(clash)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Advance one edge, updating the model from the inputs present before it.
  task automatic tick();
    logic [7:0] nab [2];
    logic [7:0] nba [2];
    for (int n = 0; n < 2; n++) begin
      nab[n] = (!ab_sel_n[n] && !ab_cap_n[n]) ? a_in[n*8 +: 8] : ref_ab[n];
      nba[n] = (!ba_sel_n[n] && !ba_cap_n[n]) ? b_in[n*8 +: 8] : ref_ba[n];
    end
    @(posedge clk);
    #1;
    for (int n = 0; n < 2; n++) begin
      ref_ab[n] = nab[n];
      ref_ba[n] = nba[n];
    end
  endtask

  // Compare every output against the control-table model.
  task automatic check_all(input string tag);
    logic [1:0]  ebd, ead;
    logic [15:0] ebv, eav;
    #1;
    ebd = ~ab_sel_n & ~ab_out_n;
    ead = ~ba_sel_n & ~ba_out_n;
    for (int n = 0; n < 2; n++) begin
      ebv[n*8 +: 8] = ebd[n] ? ref_ab[n] : 8'h00;
      eav[n*8 +: 8] = ead[n] ? ref_ba[n] : 8'h00;
    end
    chk({tag, " R4 b_drv"}, {14'd0, b_drv}, {14'd0, ebd});
    chk({tag, " R5 b_val"}, b_val, ebv);
    chk({tag, " R7 a_drv"}, {14'd0, a_drv}, {14'd0, ead});
    chk({tag, " R7 a_val"}, a_val, eav);
    chk({tag, " R8 clash"}, {14'd0, clash}, {14'd0, ebd & ead});
  endtask

  task automatic idle_ctl();
    ab_sel_n = 2'b11; ab_cap_n = 2'b11; ab_out_n = 2'b11;
    ba_sel_n = 2'b11; ba_cap_n = 2'b11; ba_out_n = 2'b11;
  endtask

  // R1: reset clears both banks
  task automatic t_reset();
    idle_ctl();
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    rst_n = 1'b0;
    for (int n = 0; n < 2; n++) begin ref_ab[n] = 8'h00; ref_ba[n] = 8'h00; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    ab_sel_n = 2'b00; ab_out_n = 2'b00;
    ba_sel_n = 2'b00; ba_out_n = 2'b00;
    #1;
    chk("R1 b_val after reset", b_val, 16'h0000);
    chk("R1 a_val after reset", a_val, 16'h0000);
    check_all("R1");
    idle_ctl();
  endtask

  // R2: capture on transparent edge, visible after the edge
  task automatic t_capture();
    ab_sel_n = 2'b00; ab_cap_n = 2'b00; ab_out_n = 2'b00;
    a_in = 16'hA5C3;
    tick();
    chk("R2 b_val after capture", b_val, 16'hA5C3);
    a_in = 16'h3C5A;
    tick();
    chk("R2 b_val follows new data", b_val, 16'h3C5A);
    check_all("R2");
  endtask

  // R3: closing the capture control or deselecting holds the value
  task automatic t_hold();
    ab_cap_n = 2'b11;
    a_in = 16'h1111;
    tick(); tick();
    chk("R3 held after capture closes", b_val, 16'h3C5A);
    ab_cap_n = 2'b00; ab_sel_n = 2'b11;
    a_in = 16'h2222;
    tick();
    ab_sel_n = 2'b00; ab_cap_n = 2'b11;
    #1;
    chk("R3 held while deselected", b_val, 16'h3C5A);
    check_all("R3");
  endtask

  // R4/R5: drive control gates output only, storage survives
  task automatic t_drive();
    ab_out_n = 2'b11;
    #1;
    chk("R4 b_drv off", {14'd0, b_drv}, 16'h0000);
    chk("R5 b_val zero when undriven", b_val, 16'h0000);
    tick();
    ab_out_n = 2'b00;
    #1;
    chk("R5 value kept across drive off", b_val, 16'h3C5A);
    check_all("R5");
  endtask

  // R6: independent byte lanes
  task automatic t_bytes();
    ab_sel_n = 2'b00; ab_out_n = 2'b00;
    ab_cap_n = 2'b10;
    a_in = 16'h7E81;
    tick();
    chk("R6 byte0 loads byte1 holds", b_val, 16'h3C81);
    ab_cap_n = 2'b01; ab_out_n = 2'b10;
    a_in = 16'h9966;
    tick();
    chk("R6 byte1 loads, byte1 undriven", b_val, 16'h0081);
    chk("R6 drive lanes", {14'd0, b_drv}, 16'h0001);
    ab_out_n = 2'b00;
    check_all("R6");
    chk("R6 byte1 stored", b_val, 16'h9981);
  endtask

  // R7: reverse path, R8: clash
  task automatic t_reverse_and_clash();
    ba_sel_n = 2'b00; ba_cap_n = 2'b00; ba_out_n = 2'b00;
    b_in = 16'hD00D;
    tick();
    chk("R7 a_val captured", a_val, 16'hD00D);
    chk("R8 clash both lanes", {14'd0, clash}, 16'h0003);
    ba_out_n = 2'b01;
    #1;
    chk("R8 clash byte1 only", {14'd0, clash}, 16'h0002);
    ab_sel_n = 2'b11;
    #1;
    chk("R8 no clash when A-to-B deselected", {14'd0, clash}, 16'h0000);
    check_all("R7");
  endtask

  // R2..R8: every control combination against the model
  task automatic t_sweep();
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] c;
      c = 12'(i);
      ab_sel_n = c[1:0];  ab_cap_n = c[3:2];  ab_out_n = c[5:4];
      ba_sel_n = c[7:6];  ba_cap_n = c[9:8];  ba_out_n = c[11:10];
      a_in = 16'(i * 16'h9E37 + 16'h1234);
      b_in = 16'(i * 16'h61C9 + 16'h0F0F);
      check_all("sweep R6");
      tick();
    end
  endtask

  initial begin
    a_in = '0; b_in = '0;
    idle_ctl();
    rst_n = 1'b0;
    t_reset();
    t_capture();
    t_hold();
    t_drive();
    t_bytes();
    t_reverse_and_clash();
    t_sweep();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule